// File: doc/BRIEF.md
# Ethernet DMA Descriptor Ring Controller

This block holds the transmit and receive descriptor rings that a host and a network DMA channel share. Every descriptor is a single status word carrying an ownership flag, start-of-packet and end-of-packet flags and a length field. Whoever owns a descriptor may act on it. Setting the ownership flag passes the descriptor to the channel, and clearing it hands the descriptor back to the host. The descriptor words live in an internal register array. Packet data movement, the MAC and bus arbitration sit outside the block.

On the transmit side, the host posts a length. The block writes a fully owned descriptor at the head index and counts it as outstanding. When the outstanding count reaches the number of transmit buffers, the producer stalls. A separate wakeup strobe tells the channel to rescan the ring. The channel releases descriptors one at a time, and the block reclaims released descriptors at the tail. On the receive side, the channel fills owned slots with frame lengths. The host pops completed slots and sees the length without the frame check sequence, together with a size-error flag. Each pop re-arms the slot one buffer count ahead.

Top module: `desc_ring_ctrl`

## Requirements
- R1: A transmit post writes the word at the head index with bit 31 (owned), bit 30 (start) and bit 29 (end) set, the length in bits 10:0 and all other bits zero. The channel sees this word on `dev_tx_desc_o`.
- R2: The channel is offered descriptors only after a wakeup strobe. Scanning stops when the descriptor at the channel pointer is not owned. Each cycle with `dev_tx_valid_o` and `dev_tx_ready_i` both high releases exactly one descriptor by clearing its ownership bit.
- R3: Every ring index steps from DEPTH-1 back to 0.
- R4: Each accepted post increments the outstanding count. When the count equals TX_BUFS, `tx_busy_o` is high, and further posts leave the head and the count unchanged.
- R5: While the count is nonzero and the tail descriptor is released, the tail advances by one per cycle. Each step decrements the count and clears `tx_busy_o`. A descriptor released at one edge is reclaimed at the next edge.
- R6: `rx_valid_o` is high when the receive descriptor at the tail is not owned. `rx_len_o` is its length field minus 4, or 0 when the field is below 4. A pop while `rx_valid_o` is low has no effect.
- R7: After reset, receive slots 0 to RX_BUFS-1 are owned with capacity BUF_BYTES (1536) and the remaining slots are not owned. Popping slot t re-arms slot (t+RX_BUFS) mod DEPTH as owned with capacity BUF_BYTES.
- R8: `rx_bad_o` is high when the reported length is 14 or less, or greater than 1514. Popping a flagged slot increments `rx_err_cnt_o`, and popping an unflagged slot leaves it unchanged.
- R9: `tx_irq_o` is high for the cycle after each transmit release. `rx_irq_o` is high for the cycle after each receive fill. Otherwise both are low.
- R10: Reset clears the head, tail and count, drops busy, stops the scan and zeroes the error count.
- R11: A channel receive write while `dev_rx_ready_o` is low changes no descriptor and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_post_i | input | 1 | Post one transmit descriptor |
| tx_post_len_i | input | LEN_W | Length of the posted packet |
| tx_wake_i | input | 1 | Wakeup strobe: channel rescans the transmit ring |
| tx_head_o | output | $clog2(DEPTH) | Next transmit slot to post |
| tx_tail_o | output | $clog2(DEPTH) | Oldest unreclaimed transmit slot |
| tx_count_o | output | $clog2(DEPTH+1) | Outstanding transmit descriptors |
| tx_busy_o | output | 1 | Producer stalled, ring full |
| dev_tx_ready_i | input | 1 | Channel takes the offered descriptor |
| dev_tx_valid_o | output | 1 | Owned descriptor offered to the channel |
| dev_tx_desc_o | output | WORD_W | Descriptor word at the channel pointer |
| tx_irq_o | output | 1 | Transmit release pulse |
| dev_rx_wr_i | input | 1 | Channel completes a receive slot |
| dev_rx_len_i | input | LEN_W | Received length including the check sequence |
| dev_rx_ready_o | output | 1 | Receive slot at the channel pointer is owned |
| dev_rx_cap_o | output | LEN_W | Buffer capacity of that slot |
| rx_pop_i | input | 1 | Host consumes the receive slot at the tail |
| rx_valid_o | output | 1 | Tail slot holds a frame |
| rx_desc_o | output | WORD_W | Descriptor word at the receive tail |
| rx_len_o | output | LEN_W | Frame length without the check sequence |
| rx_bad_o | output | 1 | Frame length out of range |
| rx_tail_o | output | $clog2(DEPTH) | Receive tail index |
| rx_err_cnt_o | output | ERR_W | Size errors counted on pop |
| rx_irq_o | output | 1 | Receive fill pulse |

## Verification
The assertions check several properties on every cycle. The busy flag must agree with the outstanding count reaching its limit, and the count must never exceed that limit. The head must hold while busy, and indices must wrap. The tail must not move with nothing outstanding. Interrupts must pulse exactly after a release or a fill. Stalled receive writes and empty pops must change nothing, and the error count may move only on a flagged pop. Other behaviour shows only in the bench's scenarios: descriptor words and their order reaching the channel, the one-edge lag of reclamation, the need for a wakeup, re-arming at the right distance, and the length limits at 18, 19, 1518 and 1519.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int FCS_BYTES = 4;
  localparam int HDR_BYTES = 14;
  localparam int MTU_BYTES = 1500;

  typedef enum logic {SCAN_IDLE, SCAN_RUN} tx_scan_e;
endpackage

// File: rtl/desc_rx_len_chk.sv
module desc_rx_len_chk
  import desc_ring_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic [LEN_W-1:0] field_i,
  output logic [LEN_W-1:0] frame_len_o,
  output logic             bad_o
);
  always_comb begin
    frame_len_o = (field_i >= LEN_W'(FCS_BYTES)) ? field_i - LEN_W'(FCS_BYTES) : '0;
    bad_o = (frame_len_o <= LEN_W'(HDR_BYTES)) ||
            (frame_len_o > LEN_W'(HDR_BYTES + MTU_BYTES));
  end
endmodule

// File: rtl/desc_tx_ring.sv
module desc_tx_ring
  import desc_ring_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TX_BUFS = 12,
  parameter int LEN_W   = 11,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_i,
  input  logic [LEN_W-1:0]  post_len_i,
  input  logic              wake_i,
  input  logic              dev_ready_i,
  output logic              dev_valid_o,
  output logic [WORD_W-1:0] dev_desc_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int OWN_B = WORD_W - 1;
  localparam int SOP_B = WORD_W - 2;
  localparam int EOP_B = WORD_W - 3;

  logic [DEPTH-1:0][WORD_W-1:0] ring_q;
  logic [IDX_W-1:0] head_q, tail_q, dptr_q;
  logic [CNT_W-1:0] count_q;
  logic             busy_q, irq_q;
  tx_scan_e         scan_q;

  logic              post_ok, reclaim, fire, dev_own, tail_own;
  logic [WORD_W-1:0] post_word;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    post_word            = '0;
    post_word[OWN_B]     = 1'b1;
    post_word[SOP_B]     = 1'b1;
    post_word[EOP_B]     = 1'b1;
    post_word[LEN_W-1:0] = post_len_i;
  end

  assign post_ok     = post_i & ~busy_q;
  assign dev_own     = ring_q[dptr_q][OWN_B];
  assign tail_own    = ring_q[tail_q][OWN_B];
  assign reclaim     = (count_q != '0) & ~tail_own;
  assign dev_valid_o = (scan_q == SCAN_RUN) & dev_own;
  assign fire        = dev_valid_o & dev_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (post_ok && head_q == IDX_W'(i)) ring_q[i] <= post_word;
        else if (fire && dptr_q == IDX_W'(i)) ring_q[i][OWN_B] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      dptr_q  <= '0;
      count_q <= '0;
      busy_q  <= 1'b0;
      scan_q  <= SCAN_IDLE;
      irq_q   <= 1'b0;
    end else begin
      if (post_ok) head_q <= step_idx(head_q);
      if (reclaim) tail_q <= step_idx(tail_q);
      if (fire)    dptr_q <= step_idx(dptr_q);
      count_q <= count_q + CNT_W'(post_ok) - CNT_W'(reclaim);
      if (reclaim) busy_q <= 1'b0;
      else if (post_ok && count_q == CNT_W'(TX_BUFS - 1)) busy_q <= 1'b1;
      if (wake_i) scan_q <= SCAN_RUN;
      else if (scan_q == SCAN_RUN && !dev_own) scan_q <= SCAN_IDLE;
      irq_q <= fire;
    end
  end

  assign dev_desc_o = ring_q[dptr_q];
  assign head_o     = head_q;
  assign tail_o     = tail_q;
  assign count_o    = count_q;
  assign busy_o     = busy_q;
  assign irq_o      = irq_q;

  AST_BUSY_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q == (count_q == CNT_W'(TX_BUFS))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(TX_BUFS)); // R4
  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && post_i) |=> $stable(head_q)); // R4
  AST_HEAD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && !busy_q && head_q == IDX_W'(DEPTH - 1)) |=> head_q == '0); // R3
  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) |=> $stable(tail_q)); // R5
  AST_TX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> irq_q); // R9
  AST_TX_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !irq_q); // R9
endmodule

// File: rtl/desc_rx_ring.sv
module desc_rx_ring #(
  parameter int DEPTH     = 16,
  parameter int RX_BUFS   = 12,
  parameter int LEN_W     = 11,
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 1536,
  parameter int ERR_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_wr_i,
  input  logic [LEN_W-1:0]  dev_len_i,
  output logic              dev_ready_o,
  output logic [LEN_W-1:0]  dev_cap_o,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] desc_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              bad_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic              irq_o
);
  localparam int OWN_B = WORD_W - 1;
  localparam int SOP_B = WORD_W - 2;
  localparam int EOP_B = WORD_W - 3;

  logic [DEPTH-1:0][WORD_W-1:0] ring_q;
  logic [IDX_W-1:0] tail_q, dptr_q, rearm_idx;
  logic [ERR_W-1:0] err_q;
  logic             irq_q;
  logic             fill, pop_ok, frame_bad;
  logic [WORD_W-1:0] arm_word, fill_word;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    arm_word             = '0;
    arm_word[OWN_B]      = 1'b1;
    arm_word[LEN_W-1:0]  = LEN_W'(BUF_BYTES);
    fill_word            = '0;
    fill_word[SOP_B]     = 1'b1;
    fill_word[EOP_B]     = 1'b1;
    fill_word[LEN_W-1:0] = dev_len_i;
  end

  assign dev_ready_o = ring_q[dptr_q][OWN_B];
  assign dev_cap_o   = ring_q[dptr_q][LEN_W-1:0];
  assign valid_o     = ~ring_q[tail_q][OWN_B];
  assign desc_o      = ring_q[tail_q];
  assign fill        = dev_wr_i & dev_ready_o;
  assign pop_ok      = pop_i & valid_o;
  assign rearm_idx   = tail_q + IDX_W'(RX_BUFS % DEPTH);

  desc_rx_len_chk #(.LEN_W(LEN_W)) i_len_chk (
    .field_i     (ring_q[tail_q][LEN_W-1:0]),
    .frame_len_o (len_o),
    .bad_o       (frame_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ring_q[i] <= (i < RX_BUFS) ? arm_word : '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill && dptr_q == IDX_W'(i)) ring_q[i] <= fill_word;
        if (pop_ok && rearm_idx == IDX_W'(i)) ring_q[i] <= arm_word;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      dptr_q <= '0;
      err_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (fill)   dptr_q <= step_idx(dptr_q);
      if (pop_ok) tail_q <= step_idx(tail_q);
      if (pop_ok && frame_bad) err_q <= err_q + 1'b1;
      irq_q <= fill;
    end
  end

  assign bad_o     = frame_bad;
  assign tail_o    = tail_q;
  assign err_cnt_o = err_q;
  assign irq_o     = irq_q;

  AST_RX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill |=> irq_q); // R9
  AST_RX_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill |=> !irq_q); // R9
  AST_ERR_ONLY_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && valid_o && bad_o) |=> $stable(err_q)); // R8
  AST_STALLED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_i && !dev_ready_o) |=> $stable(dptr_q)); // R11
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !valid_o) |=> $stable(tail_q)); // R6
  AST_REARM_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && valid_o && tail_q == '0) |=> ring_q[IDX_W'(RX_BUFS % DEPTH)][OWN_B]); // R7
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
  parameter int DEPTH     = 16,
  parameter int TX_BUFS   = 12,
  parameter int RX_BUFS   = 12,
  parameter int LEN_W     = 11,
  parameter int WORD_W    = 32,
  parameter int BUF_BYTES = 1536,
  parameter int ERR_W     = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_post_i,
  input  logic [LEN_W-1:0]  tx_post_len_i,
  input  logic              tx_wake_i,
  output logic [IDX_W-1:0]  tx_head_o,
  output logic [IDX_W-1:0]  tx_tail_o,
  output logic [CNT_W-1:0]  tx_count_o,
  output logic              tx_busy_o,
  input  logic              dev_tx_ready_i,
  output logic              dev_tx_valid_o,
  output logic [WORD_W-1:0] dev_tx_desc_o,
  output logic              tx_irq_o,
  input  logic              dev_rx_wr_i,
  input  logic [LEN_W-1:0]  dev_rx_len_i,
  output logic              dev_rx_ready_o,
  output logic [LEN_W-1:0]  dev_rx_cap_o,
  input  logic              rx_pop_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_desc_o,
  output logic [LEN_W-1:0]  rx_len_o,
  output logic              rx_bad_o,
  output logic [IDX_W-1:0]  rx_tail_o,
  output logic [ERR_W-1:0]  rx_err_cnt_o,
  output logic              rx_irq_o
);
  desc_tx_ring #(
    .DEPTH(DEPTH), .TX_BUFS(TX_BUFS), .LEN_W(LEN_W), .WORD_W(WORD_W)
  ) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .post_i      (tx_post_i),
    .post_len_i  (tx_post_len_i),
    .wake_i      (tx_wake_i),
    .dev_ready_i (dev_tx_ready_i),
    .dev_valid_o (dev_tx_valid_o),
    .dev_desc_o  (dev_tx_desc_o),
    .head_o      (tx_head_o),
    .tail_o      (tx_tail_o),
    .count_o     (tx_count_o),
    .busy_o      (tx_busy_o),
    .irq_o       (tx_irq_o)
  );

  desc_rx_ring #(
    .DEPTH(DEPTH), .RX_BUFS(RX_BUFS), .LEN_W(LEN_W), .WORD_W(WORD_W),
    .BUF_BYTES(BUF_BYTES), .ERR_W(ERR_W)
  ) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dev_wr_i    (dev_rx_wr_i),
    .dev_len_i   (dev_rx_len_i),
    .dev_ready_o (dev_rx_ready_o),
    .dev_cap_o   (dev_rx_cap_o),
    .pop_i       (rx_pop_i),
    .valid_o     (rx_valid_o),
    .desc_o      (rx_desc_o),
    .len_o       (rx_len_o),
    .bad_o       (rx_bad_o),
    .tail_o      (rx_tail_o),
    .err_cnt_o   (rx_err_cnt_o),
    .irq_o       (rx_irq_o)
  );
endmodule

// File: tb/test_desc_ring_ctrl.sv
module test_desc_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_post = 1'b0, tx_wake = 1'b0, tx_ready = 1'b0;
  logic [10:0] tx_len = '0;
  logic        rx_wr = 1'b0, rx_pop = 1'b0;
  logic [10:0] rx_len_in = '0;

  logic [3:0]  tx_head, tx_tail, rx_tail;
  logic [4:0]  tx_count;
  logic        tx_busy, tx_valid, tx_irq, rx_ready, rx_valid, rx_bad, rx_irq;
  logic [31:0] tx_desc, rx_desc;
  logic [10:0] rx_cap, rx_len;
  logic [15:0] rx_err;

  int total = 0, bad = 0, exp_err = 0;
  bit done = 0;
  int txq[$];
  int rxq[$];

  always #5 clk = ~clk;

  desc_ring_ctrl i_desc_ring_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_post_i(tx_post), .tx_post_len_i(tx_len), .tx_wake_i(tx_wake),
    .tx_head_o(tx_head), .tx_tail_o(tx_tail), .tx_count_o(tx_count), .tx_busy_o(tx_busy),
    .dev_tx_ready_i(tx_ready), .dev_tx_valid_o(tx_valid), .dev_tx_desc_o(tx_desc),
    .tx_irq_o(tx_irq),
    .dev_rx_wr_i(rx_wr), .dev_rx_len_i(rx_len_in), .dev_rx_ready_o(rx_ready),
    .dev_rx_cap_o(rx_cap), .rx_pop_i(rx_pop), .rx_valid_o(rx_valid), .rx_desc_o(rx_desc),
    .rx_len_o(rx_len), .rx_bad_o(rx_bad), .rx_tail_o(rx_tail), .rx_err_cnt_o(rx_err),
    .rx_irq_o(rx_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_frame(int f);
    return (f >= 4) ? f - 4 : 0;
  endfunction

  function automatic bit exp_bad(int f);
    return (exp_frame(f) <= 14) || (exp_frame(f) > 1514);
  endfunction

  function automatic logic [31:0] exp_tx_word(int l);
    return 32'hE000_0000 | 32'(l);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rl [12];
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 head", 32'(tx_head), 0);
    chk("R10 count", 32'(tx_count), 0);
    chk("R10 busy", 32'(tx_busy), 0);
    chk("R10 tx_valid", 32'(tx_valid), 0);
    chk("R10 err", 32'(rx_err), 0);
    chk("R7 reset armed", 32'(rx_ready), 1);
    chk("R7 reset cap", 32'(rx_cap), 1536);
    chk("R6 reset rx_valid", 32'(rx_valid), 0);

    // R2: post without wake stays hidden
    tx_post = 1; tx_len = 11'd100; tick(); tx_post = 0;
    chk("R4 count after post", 32'(tx_count), 1);
    tick(); tick();
    chk("R2 no wake no offer", 32'(tx_valid), 0);
    tx_wake = 1; tick(); tx_wake = 0;
    chk("R2 offer after wake", 32'(tx_valid), 1);
    chk("R1 word", tx_desc, exp_tx_word(100));

    // fill to the limit
    tx_post = 1; tx_len = 11'd5; tick();
    for (int i = 0; i < 10; i++) begin
      tx_len = 11'(200 + i); tick();
    end
    tx_post = 0;
    chk("R4 count at limit", 32'(tx_count), 12);
    chk("R4 busy", 32'(tx_busy), 1);
    tx_post = 1; tx_len = 11'd999; tick(); tx_post = 0;
    chk("R4 head held", 32'(tx_head), 12);
    chk("R4 count held", 32'(tx_count), 12);

    // drain in order
    tx_ready = 1;
    for (int k = 0; k < 12; k++) begin
      int e;
      e = (k == 0) ? 100 : (k == 1) ? 5 : 200 + k - 2;
      chk("R2 valid", 32'(tx_valid), 1);
      chk("R1 order", tx_desc, exp_tx_word(e));
      tick();
      chk("R9 tx irq", 32'(tx_irq), 1);
      if (k == 0) begin
        chk("R5 busy before reclaim", 32'(tx_busy), 1);
        chk("R5 count before reclaim", 32'(tx_count), 12);
      end
      if (k == 1) begin
        chk("R5 busy cleared", 32'(tx_busy), 0);
        chk("R5 count after reclaim", 32'(tx_count), 11);
      end
    end
    tx_ready = 0;
    tick();
    chk("R5 count drained", 32'(tx_count), 0);
    chk("R5 tail", 32'(tx_tail), 12);
    chk("R9 tx irq low", 32'(tx_irq), 0);

    // R3 wrap
    tx_ready = 1; tx_post = 1; tx_wake = 1;
    for (int i = 0; i < 6; i++) begin
      tx_len = 11'(300 + i); tick();
    end
    tx_post = 0; tx_wake = 0;
    repeat (4) tick();
    tx_ready = 0;
    chk("R3 head wrap", 32'(tx_head), 2);
    chk("R3 tail wrap", 32'(tx_tail), 2);
    chk("R5 count zero", 32'(tx_count), 0);

    // receive directed
    rl = '{68, 18, 19, 1518, 1519, 100, 100, 100, 100, 100, 100, 100};
    rx_wr = 1;
    for (int i = 0; i < 12; i++) begin
      rx_len_in = 11'(rl[i]); tick();
      if (i == 0) begin
        chk("R9 rx irq", 32'(rx_irq), 1);
        chk("R6 rx valid", 32'(rx_valid), 1);
        chk("R6 rx len", 32'(rx_len), 64);
        chk("R6 rx word", rx_desc, 32'h6000_0044);
      end
    end
    rx_wr = 0;
    chk("R7 stall at unarmed slot", 32'(rx_ready), 0);
    rx_wr = 1; rx_len_in = 11'd77; tick(); rx_wr = 0;
    chk("R11 no irq", 32'(rx_irq), 0);
    chk("R11 tail slot kept", 32'(rx_len), 64);
    rx_pop = 1;
    for (int k = 0; k < 12; k++) begin
      chk("R6 valid", 32'(rx_valid), 1);
      chk("R6 len", 32'(rx_len), 32'(exp_frame(rl[k])));
      chk("R8 bad flag", 32'(rx_bad), 32'(exp_bad(rl[k])));
      if (exp_bad(rl[k])) exp_err++;
      tick();
      chk("R8 err count", 32'(rx_err), 32'(exp_err));
      if (k == 0) begin
        chk("R7 rearmed", 32'(rx_ready), 1);
        chk("R7 rearm cap", 32'(rx_cap), 1536);
      end
    end
    rx_pop = 0;
    chk("R6 empty", 32'(rx_valid), 0);
    rx_pop = 1; tick(); rx_pop = 0;
    chk("R6 empty pop ignored", 32'(rx_tail), 12);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic d_post, d_wake, d_ready, d_wr, d_pop;
      int   l, f;
      d_post  = ($urandom % 3) == 0;
      d_wake  = ($urandom % 4) == 0;
      d_ready = ($urandom % 2) == 0;
      d_wr    = ($urandom % 3) == 0;
      d_pop   = ($urandom % 3) == 0;
      l = $urandom % 2048;
      case ($urandom % 8)
        0: f = 18; 1: f = 19; 2: f = 1518; 3: f = 1519;
        default: f = $urandom % 2048;
      endcase
      if (d_ready && tx_valid) begin
        chk("R1 random order", tx_desc, exp_tx_word(txq.pop_front()));
      end
      if (d_post && !tx_busy) txq.push_back(l);
      if (d_wr && rx_ready) rxq.push_back(f);
      if (d_pop && rx_valid) begin
        int e;
        e = rxq.pop_front();
        chk("R6 random len", 32'(rx_len), 32'(exp_frame(e)));
        chk("R8 random bad", 32'(rx_bad), 32'(exp_bad(e)));
        if (exp_bad(e)) exp_err++;
      end
      tx_post = d_post; tx_len = 11'(l); tx_wake = d_wake; tx_ready = d_ready;
      rx_wr = d_wr; rx_len_in = 11'(f); rx_pop = d_pop;
      tick();
    end
    tx_post = 0; rx_wr = 0; rx_pop = 0; tx_ready = 0;
    tx_wake = 1; tick(); tx_wake = 0;
    tx_ready = 1;
    for (int c = 0; c < 40; c++) begin
      if (tx_valid) chk("R1 drain order", tx_desc, exp_tx_word(txq.pop_front()));
      tick();
    end
    tx_ready = 0;
    chk("R5 drained", 32'(tx_count), 0);
    chk("R2 all sent", 32'(txq.size()), 0);
    rx_pop = 1;
    for (int c = 0; c < 20; c++) begin
      if (rx_valid) begin
        int e;
        e = rxq.pop_front();
        chk("R6 drain len", 32'(rx_len), 32'(exp_frame(e)));
        if (exp_bad(e)) exp_err++;
      end
      tick();
    end
    rx_pop = 0;
    chk("R6 rx drained", 32'(rxq.size()), 0);
    chk("R8 final err", 32'(rx_err), 32'(exp_err));
    finish_run();
  end
endmodule